// File: doc/BRIEF.md
# Descriptor Ring Pipe Engine

This block is the front end of a single scatter-gather DMA pipe. Software places 8-byte descriptors in a small local descriptor store and sets up a circular ring over that store: a base address, a ring size in bytes and a control word that enables the pipe and picks its direction. New work is handed over by writing an event value. This value is the byte offset, inside the ring, of the last descriptor just made valid. The engine then walks the ring from where it stands up to and including that descriptor. For each legal descriptor it emits one transfer request (address, length, flags, direction) on a valid/ready handshake.

The engine checks every descriptor's control flags and length before issuing it. Malformed entries are skipped, and each one raises an error pulse. Status pulses tell a neighbouring interrupt block when a descriptor completes, when a transfer end is reached and when the ring has run dry. The current byte offset is always visible on a port, so software knows how far the engine has advanced and where it may write next.

Top module: `dring_engine`

## Requirements
- R1: A descriptor word holds the buffer address in bits 31:0, the byte length in bits 47:32, a reserved byte in bits 55:48 and the flags byte in bits 63:56. Each issued request carries exactly that address, length and flags byte. Its direction bit is the control direction bit that was set when the descriptor was checked.
- R2: Requests follow the ring order. While `req_valid` is high and `req_ready` is low, the request and its fields hold steady. Exactly one request completes per legal descriptor.
- R3: Writing select code 4 posts an event. The value is masked to the ring size and its low 3 bits are cleared. The engine then consumes every descriptor from its current offset up to and including the one at that offset, and offsets wrap modulo the ring size.
- R4: An event is rejected if, once accepted, it would leave the whole ring outstanding, that is when (event + 8) mod size equals the current offset. A rejected event pulses `ev_reject` and adds no work. With a ring size of 8, every event is rejected.
- R5: A descriptor is illegal if it has lock (flag bit 2) together with unlock (bit 1), or end-of-transfer (bit 6) together with command (bit 3), or a zero length, or a nonzero reserved byte. An illegal descriptor raises a one-cycle `irq_err`, issues no request and is stepped over.
- R6: Each completed request gives one `irq_done` pulse. If its flags have end-of-transfer (bit 6) set, `irq_xfer_end` pulses in the same cycle. When the offset reaches the end of the posted work, `irq_empty` pulses once.
- R7: `cur_ofs` is the byte offset of the next descriptor to be consumed. It advances by 8 per consumed descriptor, modulo the ring size.
- R8: Writing select code 0 sets the control word: bit 1 enable, bit 3 direction, bit 5 system mode. Descriptors are fetched only while both enable and system mode are set. Otherwise posted work waits.
- R9: Writing select code 1 sets the pipe reset (bit 0). While it is 1, the offset and the end of work are forced to zero, no request is valid, and events are ignored.
- R10: Writing select code 3 sets the ring size in bytes. The write takes effect only if the value is a power of two from 8 up to 8 × DEPTH. Any other value is ignored. The size after reset is 8 × DEPTH.
- R11: Writing select code 2 sets the ring base byte address. Its low 3 bits are ignored, so the descriptor at byte offset o sits at store index (base/8 + o/8) mod DEPTH.
- R12: After reset, `req_valid`, every status pulse and `cur_ofs` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 pipe reset, 2 base, 3 size, 4 event) |
| cfg_wdata | input | 32 | Configuration write data |
| dmem_we | input | 1 | Descriptor store write strobe |
| dmem_idx | input | IDXW | Descriptor store write index |
| dmem_wdata | input | 64 | Descriptor word to store |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Transfer request accepted |
| req_addr | output | 32 | Request buffer address |
| req_len | output | 16 | Request byte length |
| req_flags | output | 8 | Request flags byte |
| req_dir | output | 1 | Request direction |
| cur_ofs | output | OFS_W | Current byte offset in the ring |
| ev_reject | output | 1 | Pulse: event refused as overfilling |
| irq_done | output | 1 | Pulse: descriptor completed |
| irq_empty | output | 1 | Pulse: no further posted work |
| irq_xfer_end | output | 1 | Pulse: end-of-transfer descriptor completed |
| irq_err | output | 1 | Pulse: illegal descriptor skipped |

## Verification
The ring walk is swept over every legal batch count for each ring size from 16 to 128 bytes. Each sweep runs with both an aligned base and an unaligned base, and batches follow one another, so the offset wraps repeatedly and the store index wraps past the end of the store. This shows whether the modulo arithmetic on offsets and indices is right. Ready is held high on some batches and toggled on others, which separates the handshake timing from the fetch order. A stalled request is held to check field stability. Separate patterns cover the full-ring event, the one-descriptor ring, invalid size writes, a masked over-range event, each illegal flag combination and the zero length. They also cover gating by enable and system mode, and events written while the pipe reset is held. Each of these patterns isolates one rule.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int DESC_BYTES = 8;

    // flag bit positions inside the descriptor flags byte
    localparam int FLG_EOT    = 6;
    localparam int FLG_CMD    = 3;
    localparam int FLG_LOCK   = 2;
    localparam int FLG_UNLOCK = 1;

    // control word bit positions
    localparam int CTL_EN  = 1;
    localparam int CTL_DIR = 3;
    localparam int CTL_SYS = 5;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_PRST  = 3'd1,
        SEL_BASE  = 3'd2,
        SEL_SIZE  = 3'd3,
        SEL_EVENT = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [7:0]  flags;
        logic [7:0]  rsvd;
        logic [15:0] len;
        logic [31:0] addr;
    } desc_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_CHECK = 2'd1,
        W_ISSUE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/dring_store.sv
module dring_store
    import dring_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  desc_t           wr_data,
    input  logic            rd_en,
    input  logic [IDXW-1:0] rd_idx,
    output desc_t           rd_data
);

    desc_t mem [DEPTH];
    desc_t rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = mem[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/dring_regs.sv
module dring_regs
    import dring_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OFS_W = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic [OFS_W-1:0] cur_ofs,
    output logic             pipe_en,
    output logic             pipe_dir,
    output logic             pipe_sys,
    output logic             pipe_rst,
    output logic [IDXW-1:0]  base_idx,
    output logic [OFS_W-1:0] size_mask,
    output logic [OFS_W-1:0] fin_ofs,
    output logic             ev_reject
);

    localparam int               RING_MAX = DEPTH * DESC_BYTES;
    localparam logic [OFS_W-1:0] STEP     = OFS_W'(DESC_BYTES);
    localparam logic [OFS_W-1:0] ALIGN    = ~OFS_W'(DESC_BYTES - 1);

    typedef struct packed {
        logic             en;
        logic             dir;
        logic             sys;
        logic             prst;
        logic [IDXW-1:0]  base;
        logic [OFS_W-1:0] size;
        logic [OFS_W-1:0] fin;
        logic             rej;
    } regs_t;

    regs_t            r_d, r_q;
    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] ev;
    logic [OFS_W-1:0] nfin;

    function automatic logic size_ok(input logic [31:0] w);
        return (w >= 32'd8) && (w <= 32'(RING_MAX)) && ((w & (w - 32'd1)) == 32'd0);
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.rej = 1'b0;
        mask    = r_q.size - OFS_W'(1);
        ev      = cfg_wdata[OFS_W-1:0] & mask & ALIGN;
        nfin    = (ev + STEP) & mask;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_CTRL: begin
                    r_d.en  = cfg_wdata[CTL_EN];
                    r_d.dir = cfg_wdata[CTL_DIR];
                    r_d.sys = cfg_wdata[CTL_SYS];
                end
                SEL_PRST: r_d.prst = cfg_wdata[0];
                SEL_BASE: r_d.base = cfg_wdata[IDXW+2:3];
                SEL_SIZE: begin
                    if (size_ok(cfg_wdata)) begin
                        r_d.size = cfg_wdata[OFS_W-1:0];
                    end
                end
                SEL_EVENT: begin
                    if (!r_q.prst) begin
                        if (nfin == cur_ofs) begin
                            r_d.rej = 1'b1;
                        end else begin
                            r_d.fin = nfin;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (r_q.prst) begin
            r_d.fin = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.size <= OFS_W'(RING_MAX);
        end else begin
            r_q <= r_d;
        end
    end

    assign pipe_en   = r_q.en;
    assign pipe_dir  = r_q.dir;
    assign pipe_sys  = r_q.sys;
    assign pipe_rst  = r_q.prst;
    assign base_idx  = r_q.base;
    assign size_mask = r_q.size - OFS_W'(1);
    assign fin_ofs   = r_q.fin;
    assign ev_reject = r_q.rej;

endmodule

// File: rtl/dring_walker.sv
module dring_walker
    import dring_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OFS_W = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_en,
    input  logic             pipe_dir,
    input  logic             pipe_sys,
    input  logic             pipe_rst,
    input  logic [IDXW-1:0]  base_idx,
    input  logic [OFS_W-1:0] size_mask,
    input  logic [OFS_W-1:0] fin_ofs,
    input  desc_t            rd_data,
    output logic             rd_en,
    output logic [IDXW-1:0]  rd_idx,
    input  logic             req_ready,
    output logic             req_valid,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_len,
    output logic [7:0]       req_flags,
    output logic             req_dir,
    output logic [OFS_W-1:0] cur_ofs,
    output logic             irq_done,
    output logic             irq_empty,
    output logic             irq_xfer_end,
    output logic             irq_err
);

    localparam logic [OFS_W-1:0] STEP = OFS_W'(DESC_BYTES);

    typedef struct packed {
        walk_state_e      st;
        logic [OFS_W-1:0] cur;
        logic [31:0]      addr;
        logic [15:0]      len;
        logic [7:0]       flags;
        logic             dir;
        logic             done;
        logic             empty;
        logic             xend;
        logic             err;
    } walk_t;

    walk_t            w_d, w_q;
    logic [OFS_W-1:0] nxt_ofs;
    logic             bad;

    assign rd_idx = base_idx + w_q.cur[IDXW+2:3];

    always_comb begin
        w_d       = w_q;
        w_d.done  = 1'b0;
        w_d.empty = 1'b0;
        w_d.xend  = 1'b0;
        w_d.err   = 1'b0;
        rd_en     = 1'b0;
        nxt_ofs   = (w_q.cur + STEP) & size_mask;
        bad       = (rd_data.flags[FLG_LOCK] && rd_data.flags[FLG_UNLOCK])
                 || (rd_data.flags[FLG_EOT] && rd_data.flags[FLG_CMD])
                 || (rd_data.len == 16'd0)
                 || (rd_data.rsvd != 8'd0);
        case (w_q.st)
            W_IDLE: begin
                if (pipe_en && pipe_sys && (w_q.cur != fin_ofs)) begin
                    rd_en  = 1'b1;
                    w_d.st = W_CHECK;
                end
            end
            W_CHECK: begin
                if (bad) begin
                    w_d.err   = 1'b1;
                    w_d.cur   = nxt_ofs;
                    w_d.empty = (nxt_ofs == fin_ofs);
                    w_d.st    = W_IDLE;
                end else begin
                    w_d.addr  = rd_data.addr;
                    w_d.len   = rd_data.len;
                    w_d.flags = rd_data.flags;
                    w_d.dir   = pipe_dir;
                    w_d.st    = W_ISSUE;
                end
            end
            W_ISSUE: begin
                if (req_ready) begin
                    w_d.done  = 1'b1;
                    w_d.xend  = w_q.flags[FLG_EOT];
                    w_d.cur   = nxt_ofs;
                    w_d.empty = (nxt_ofs == fin_ofs);
                    w_d.st    = W_IDLE;
                end
            end
            default: w_d.st = W_IDLE;
        endcase
        if (pipe_rst) begin
            w_d   = '0;
            rd_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign req_valid    = (w_q.st == W_ISSUE);
    assign req_addr     = w_q.addr;
    assign req_len      = w_q.len;
    assign req_flags    = w_q.flags;
    assign req_dir      = w_q.dir;
    assign cur_ofs      = w_q.cur;
    assign irq_done     = w_q.done;
    assign irq_empty    = w_q.empty;
    assign irq_xfer_end = w_q.xend;
    assign irq_err      = w_q.err;

endmodule

// File: rtl/dring_engine.sv
module dring_engine
    import dring_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OFS_W = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             dmem_we,
    input  logic [IDXW-1:0]  dmem_idx,
    input  logic [63:0]      dmem_wdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_len,
    output logic [7:0]       req_flags,
    output logic             req_dir,
    output logic [OFS_W-1:0] cur_ofs,
    output logic             ev_reject,
    output logic             irq_done,
    output logic             irq_empty,
    output logic             irq_xfer_end,
    output logic             irq_err
);

    logic             pipe_en;
    logic             pipe_dir;
    logic             pipe_sys;
    logic             pipe_rst;
    logic [IDXW-1:0]  base_idx;
    logic [OFS_W-1:0] size_mask;
    logic [OFS_W-1:0] fin_ofs;
    logic             rd_en;
    logic [IDXW-1:0]  rd_idx;
    desc_t            rd_data;

    dring_regs #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cur_ofs   (cur_ofs),
        .pipe_en   (pipe_en),
        .pipe_dir  (pipe_dir),
        .pipe_sys  (pipe_sys),
        .pipe_rst  (pipe_rst),
        .base_idx  (base_idx),
        .size_mask (size_mask),
        .fin_ofs   (fin_ofs),
        .ev_reject (ev_reject)
    );

    dring_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dmem_we),
        .wr_idx  (dmem_idx),
        .wr_data (desc_t'(dmem_wdata)),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    dring_walker #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .pipe_en      (pipe_en),
        .pipe_dir     (pipe_dir),
        .pipe_sys     (pipe_sys),
        .pipe_rst     (pipe_rst),
        .base_idx     (base_idx),
        .size_mask    (size_mask),
        .fin_ofs      (fin_ofs),
        .rd_data      (rd_data),
        .rd_en        (rd_en),
        .rd_idx       (rd_idx),
        .req_ready    (req_ready),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_flags    (req_flags),
        .req_dir      (req_dir),
        .cur_ofs      (cur_ofs),
        .irq_done     (irq_done),
        .irq_empty    (irq_empty),
        .irq_xfer_end (irq_xfer_end),
        .irq_err      (irq_err)
    );

endmodule

// File: rtl/dring_engine_chk.sv
module dring_engine_chk #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_addr,
    input logic [15:0]      req_len,
    input logic [7:0]       req_flags,
    input logic [OFS_W-1:0] cur_ofs,
    input logic             ev_reject,
    input logic             irq_done,
    input logic             irq_xfer_end,
    input logic             irq_err,
    input logic             pipe_rst,
    input logic [OFS_W-1:0] fin_ofs
);

    // R2: a stalled request keeps its fields
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !pipe_rst)
        |=> (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_flags)));

    // R4: a refused event leaves the end of work untouched
    p_reject_keeps_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reject |-> $stable(fin_ofs));

    // R5: a skipped descriptor never also counts as completed
    p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_err, irq_done}));

    // R6: transfer end only comes with a completion
    p_xend_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer_end |-> irq_done);

    // R7: offset stays on descriptor boundaries
    p_ofs_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ofs[2:0] == 3'd0);

    // R9: held pipe reset clears the walker
    p_prst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_rst |=> (!req_valid && cur_ofs == '0));

endmodule

bind dring_engine dring_engine_chk #(.OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .req_flags    (req_flags),
    .cur_ofs      (cur_ofs),
    .ev_reject    (ev_reject),
    .irq_done     (irq_done),
    .irq_xfer_end (irq_xfer_end),
    .irq_err      (irq_err),
    .pipe_rst     (pipe_rst),
    .fin_ofs      (fin_ofs)
);

// File: tb/dring_engine_tb.sv
module dring_engine_tb;

    localparam int DEPTH = 16;
    localparam int OFS_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        dmem_we;
    logic [3:0]  dmem_idx;
    logic [63:0] dmem_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [15:0] req_len;
    logic [7:0]  req_flags;
    logic        req_dir;
    logic [15:0] cur_ofs;
    logic        ev_reject;
    logic        irq_done;
    logic        irq_empty;
    logic        irq_xfer_end;
    logic        irq_err;

    always #4 clk = ~clk;

    dring_engine #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dmem_we(dmem_we), .dmem_idx(dmem_idx), .dmem_wdata(dmem_wdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_flags(req_flags), .req_dir(req_dir),
        .cur_ofs(cur_ofs), .ev_reject(ev_reject),
        .irq_done(irq_done), .irq_empty(irq_empty),
        .irq_xfer_end(irq_xfer_end), .irq_err(irq_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [63:0] mdl [DEPTH];
    logic [31:0] lg_addr  [1024];
    logic [15:0] lg_len   [1024];
    logic [7:0]  lg_flags [1024];
    logic        lg_dir   [1024];
    int n_req = 0;
    int c_done = 0, c_empty = 0, c_xend = 0, c_err = 0, c_rej = 0;
    int s_req, s_done, s_empty, s_xend, s_err, s_rej;

    int m_cur = 0, m_size = 128, m_base_idx = 0, m_dir = 0;
    int rdy_mode = 0;
    int tick = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready && n_req < 1024) begin
                lg_addr[n_req]  = req_addr;
                lg_len[n_req]   = req_len;
                lg_flags[n_req] = req_flags;
                lg_dir[n_req]   = req_dir;
                n_req++;
            end
            if (irq_done)     c_done++;
            if (irq_empty)    c_empty++;
            if (irq_xfer_end) c_xend++;
            if (irq_err)      c_err++;
            if (ev_reject)    c_rej++;
        end
    end

    always @(negedge clk) begin
        tick++;
        case (rdy_mode)
            0:       req_ready = 1'b1;
            1:       req_ready = tick[0];
            default: req_ready = 1'b0;
        endcase
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_desc(input int idx, input logic [7:0] fl, input logic [7:0] rs,
                           input logic [15:0] len, input logic [31:0] addr);
        logic [63:0] w;
        w = {fl, rs, len, addr};
        mdl[idx] = w;
        @(negedge clk);
        dmem_we = 1'b1; dmem_idx = 4'(idx); dmem_wdata = w;
        @(negedge clk);
        dmem_we = 1'b0;
    endtask

    task automatic fill(input int salt);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] fl;
            fl = (i % 3 == 0) ? 8'h80 : ((i % 3 == 1) ? 8'h20 : 8'h11);
            wr_desc(i, fl, 8'h00, 16'(i * 3 + salt + 1),
                    32'h4000_0000 | (32'(salt) << 16) | (32'(i) << 4));
        end
    endtask

    function automatic bit legal(input logic [63:0] w);
        logic [7:0] f;
        f = w[63:56];
        return !((f[2] && f[1]) || (f[6] && f[3]) || (w[47:32] == 16'd0) || (w[55:48] != 8'd0));
    endfunction

    task automatic snap();
        s_req = n_req; s_done = c_done; s_empty = c_empty;
        s_xend = c_xend; s_err = c_err; s_rej = c_rej;
    endtask

    task automatic post(input int n);
        int e;
        e = (m_cur + (n - 1) * 8) & (m_size - 1);
        snap();
        cfg(3'd4, 32'(e));
    endtask

    task automatic prst();
        cfg(3'd1, 32'd1);
        cfg(3'd1, 32'd0);
        m_cur = 0;
    endtask

    task automatic drain(input int n, input string tag);
        int g, r, nl, nx, nerr;
        g = 0;
        while (((c_done - s_done) + (c_err - s_err)) < n && g < 40 * n + 40) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
        r = s_req; nl = 0; nx = 0; nerr = 0;
        for (int k = 0; k < n; k++) begin
            int ofs, idx;
            logic [63:0] w;
            ofs = (m_cur + 8 * k) & (m_size - 1);
            idx = (m_base_idx + ofs / 8) % DEPTH;
            w = mdl[idx];
            if (legal(w)) begin
                if (r < 1024) begin
                    chk({tag, " addr"},  64'(lg_addr[r]),  64'(w[31:0]));
                    chk({tag, " len"},   64'(lg_len[r]),   64'(w[47:32]));
                    chk({tag, " flags"}, 64'(lg_flags[r]), 64'(w[63:56]));
                    chk({tag, " dir"},   64'(lg_dir[r]),   64'(m_dir));
                end
                r++; nl++;
                if (w[62]) nx++;
            end else begin
                nerr++;
            end
        end
        chk({tag, " request count"}, 64'(n_req - s_req), 64'(nl));
        chk("R6 done pulses",  64'(c_done - s_done),  64'(nl));
        chk("R6 xfer end",     64'(c_xend - s_xend),  64'(nx));
        chk("R6 empty pulse",  64'(c_empty - s_empty), 64'd1);
        chk("R5 error pulses", 64'(c_err - s_err),    64'(nerr));
        m_cur = (m_cur + 8 * n) & (m_size - 1);
        chk("R7 offset", 64'(cur_ofs), 64'(m_cur));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = 32'd0;
        dmem_we = 1'b0; dmem_idx = 4'd0; dmem_wdata = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 req_valid", 64'(req_valid), 64'd0);
        chk("R12 cur_ofs",   64'(cur_ofs),   64'd0);
        chk("R12 pulses", 64'({ev_reject, irq_done, irq_empty, irq_xfer_end, irq_err}), 64'd0);

        fill(1);
        cfg(3'd0, 32'h2A);   // enable, direction 1, system mode
        m_dir = 1;
        // R10: size after reset is 8*DEPTH, so a 3-entry batch runs untouched
        post(3);
        drain(3, "R3");

        // sweep of ring sizes, bases and batch counts
        for (int si = 0; si < 4; si++) begin
            int sz;
            sz = 16 << si;
            m_dir = si % 2;
            cfg(3'd0, (m_dir != 0) ? 32'h2A : 32'h22);
            cfg(3'd3, 32'(sz));
            m_size = sz;
            for (int bi = 0; bi < 2; bi++) begin
                int base;
                base = (bi == 0) ? 0 : 43;
                fill(si * 2 + bi + 2);
                cfg(3'd2, 32'(base));
                m_base_idx = base / 8;
                prst();
                for (int n = 1; n < sz / 8; n++) begin
                    rdy_mode = n % 2;
                    post(n);
                    drain(n, (bi == 0) ? "R1" : "R11");
                end
            end
        end
        rdy_mode = 0;

        // R4: full-ring event refused
        cfg(3'd2, 32'd0); m_base_idx = 0;
        cfg(3'd3, 32'd32); m_size = 32;
        prst();
        post(3); drain(3, "R4 setup");
        snap();
        cfg(3'd4, 32'((m_cur + 24) & 31));
        repeat (20) @(negedge clk);
        chk("R4 reject pulse", 64'(c_rej - s_rej), 64'd1);
        chk("R4 no request", 64'(n_req - s_req), 64'd0);
        chk("R4 offset kept", 64'(cur_ofs), 64'(m_cur));
        post(3); drain(3, "R4 after");
        // R4: one-entry ring rejects everything
        cfg(3'd3, 32'd8); m_size = 8;
        prst();
        snap();
        cfg(3'd4, 32'd0);
        repeat (20) @(negedge clk);
        chk("R4 size8 reject", 64'(c_rej - s_rej), 64'd1);
        chk("R4 size8 no request", 64'(n_req - s_req), 64'd0);

        // R10: invalid sizes ignored, then event 40 masks to 8 under size 32
        cfg(3'd3, 32'd32); m_size = 32;
        prst();
        cfg(3'd3, 32'd256);
        cfg(3'd3, 32'd24);
        cfg(3'd3, 32'd0);
        snap();
        cfg(3'd4, 32'd40);
        drain(2, "R10");

        // R8: enable and system mode gating
        cfg(3'd0, 32'h20); m_dir = 0;
        post(2);
        repeat (30) @(negedge clk);
        chk("R8 enable off no request", 64'(n_req - s_req), 64'd0);
        chk("R8 enable off offset", 64'(cur_ofs), 64'(m_cur));
        cfg(3'd0, 32'h22);
        drain(2, "R8");
        cfg(3'd0, 32'h02);
        post(2);
        repeat (30) @(negedge clk);
        chk("R8 sys off no request", 64'(n_req - s_req), 64'd0);
        cfg(3'd0, 32'h22);
        drain(2, "R8");

        // R5 and R6: illegal entries, zero length, end-of-transfer
        cfg(3'd3, 32'd128); m_size = 128;
        prst();
        wr_desc(0, 8'h06, 8'h00, 16'd5, 32'h1111_0000);
        wr_desc(1, 8'h48, 8'h00, 16'd5, 32'h2222_0000);
        wr_desc(2, 8'h80, 8'h00, 16'd0, 32'h3333_0000);
        wr_desc(3, 8'h40, 8'h00, 16'd9, 32'h4444_0000);
        wr_desc(4, 8'h80, 8'h07, 16'd9, 32'h5555_0000);
        wr_desc(5, 8'hC0, 8'h00, 16'd7, 32'h6666_0000);
        post(6);
        drain(6, "R5");

        // R2: stalled request holds
        rdy_mode = 2;
        post(1);
        begin
            int g;
            logic [31:0] a0;
            logic [15:0] l0;
            logic [7:0]  f0;
            g = 0;
            while (!req_valid && g < 50) begin @(negedge clk); g++; end
            a0 = req_addr; l0 = req_len; f0 = req_flags;
            repeat (6) @(negedge clk);
            chk("R2 held valid", 64'(req_valid), 64'd1);
            chk("R2 held addr",  64'(req_addr),  64'(a0));
            chk("R2 held len",   64'(req_len),   64'(l0));
            chk("R2 held flags", 64'(req_flags), 64'(f0));
        end
        rdy_mode = 0;
        drain(1, "R2");

        // R9: pipe reset held
        cfg(3'd1, 32'd1);
        @(negedge clk);
        chk("R9 offset cleared", 64'(cur_ofs), 64'd0);
        chk("R9 no valid", 64'(req_valid), 64'd0);
        snap();
        cfg(3'd4, 32'd16);
        cfg(3'd1, 32'd0);
        m_cur = 0;
        repeat (20) @(negedge clk);
        chk("R9 event ignored", 64'(n_req - s_req), 64'd0);
        chk("R9 no reject", 64'(c_rej - s_rej), 64'd0);
        chk("R9 offset stays", 64'(cur_ofs), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule